// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block gathers a wide set of interrupt sources into fixed 32-bit banks and presents them to a processor through a small word-addressed register interface. Each source has three bits. A pending bit latches the source's rising edge. An enable bit lets the source take part in arbitration. A mask bit, when set, hides it. A single request line tells the processor that at least one source is enabled, unmasked and pending. A vector register names the winning source.

Software reads the vector, handles that source and clears its pending bit by writing a one to it, then reads the vector again. Because the vector is computed combinationally from the live pending, enable and mask words, each read already reflects the clear made just before it. A protection bit can restrict all register writes to privileged bus cycles. A small external-source control field is held for the external non-maskable pin logic, which sits outside this block.

The write path is a single accept decision: a write is taken when protection is off or the privilege input is high, and dropped otherwise. The block has no state machine; every register updates in the same cycle as the accepted write or the source edge.

Top module: `intc_vec_top`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Source n maps to bank n/32, bit n%32. The pending word of bank k is at byte offset 0x10+4k, its enable word at 0x40+4k and its mask word at 0x50+4k. The bank decode uses address bits [7:2]; bits [1:0] are ignored.
- R3: On a write to a pending word, every data bit at 1 clears the matching pending bit. Data bits at 0 leave their pending bits unchanged.
- R4: A pending source raises `irq_o` only when its enable bit is 1, and `irq_o` is high in the cycle after its pending bit becomes set.
- R5: A source whose mask bit is 1 neither raises `irq_o` nor wins the vector.
- R6: The vector register at offset 0x00 returns the lowest-numbered active source index shifted left by two bits. An active source is one that is pending, enabled and not masked.
- R7: With no active source, the vector reads zero and `irq_o` is low.
- R8: A pending bit is set on the clock edge that sees a rising edge on its source. If a clear write to the same bit lands in that cycle, the set wins.
- R9: The protection register at 0x08 holds its enable at bit 0. While it is 1, a write with `bus_priv` low changes no register, the protection register included.
- R10: The external-source control register at 0x0C stores a 2-bit type field in bits [1:0]. Its upper bits read zero.
- R11: Reads of unmapped offsets and of the fast-interrupt pending words (0x20+4k) return zero. Writes to those offsets have no effect.
- R12: A source held high sets its pending bit only once. After the bit is cleared it stays clear while the source remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 96 | Interrupt source inputs |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Privileged access qualifier |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Several properties are checked on every cycle:
- the winning index is active and has no lower-numbered active source below it;
- `irq_o` always points at a source that is pending, enabled and unmasked;
- a rising source is never lost to a simultaneous clear;
- a clear leaves its bits low unless a new edge arrives;
- a blocked unprivileged write leaves the control state unchanged.

Other behaviour can only be shown by the bench's scenarios:
- the address decode of each bank;
- reads of zero from unmapped and fast-pending offsets;
- the stored width of the external-source field;
- the service loop of read-vector, clear, read again;
- the behaviour of a source that is held high.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;
    localparam int BANK_W_DEF = 32;
    localparam int BANKS_DEF  = 3;
    localparam int EXT_W_DEF  = 2;
    // word-index offsets (byte offset / 4)
    localparam int W_VEC   = 0;
    localparam int W_PROT  = 2;
    localparam int W_EXT   = 3;
    localparam int W_PEND  = 4;
    localparam int W_FAST  = 8;
    localparam int W_EN    = 16;
    localparam int W_MASK  = 20;
endpackage

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_i,
    input  logic         wr_pend,
    input  logic         wr_en,
    input  logic         wr_mask,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] src_q, pend_q, en_q, mask_q;
    logic [W-1:0] rise, clr;

    assign rise = src_i & ~src_q;
    assign clr  = wr_pend ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            src_q  <= src_i;
            pend_q <= (pend_q & ~clr) | rise;
            if (wr_en)   en_q   <= wdata;
            if (wr_mask) mask_q <= wdata;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign act_o  = pend_q & en_q & ~mask_q;

    // R8: a rising source is never lost, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R3: cleared bits without a new edge are low afterwards
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pend |=> ((pend_q & $past(wdata & ~rise)) == '0));
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int N = 96,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  act_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

    // R6: winner is active and nothing lower-numbered is active
    a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> (act_i[idx_o] &&
                     ((act_i & ((N'(1) << idx_o) - N'(1))) == '0)));

    // R7: no winner only when nothing is active
    a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (act_i == '0));
endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
    import intc_vec_pkg::*;
#(
    parameter int BANKS  = BANKS_DEF,
    parameter int BANK_W = BANK_W_DEF,
    parameter int EXT_W  = EXT_W_DEF,
    parameter int ADDR_W = 8,
    localparam int NSRC  = BANKS * BANK_W,
    localparam int IW    = $clog2(NSRC),
    localparam int WA    = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BANK_W-1:0] bus_wdata,
    input  logic              bus_priv,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic [WA-1:0]      word;
    logic               wr_ok;
    logic               prot_q;
    logic [EXT_W-1:0]   ext_q;
    logic [NSRC-1:0]    pend_all, en_all, mask_all, act_all;
    logic               found;
    logic [IW-1:0]      win;

    assign word  = bus_addr[ADDR_W-1:2];
    assign wr_ok = bus_wr & (~prot_q | bus_priv);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [BANK_W-1:0] p, e, m, a;
        intc_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*BANK_W +: BANK_W]),
            .wr_pend (wr_ok && (int'(word) == W_PEND + b)),
            .wr_en   (wr_ok && (int'(word) == W_EN + b)),
            .wr_mask (wr_ok && (int'(word) == W_MASK + b)),
            .wdata   (bus_wdata),
            .pend_o  (p),
            .en_o    (e),
            .mask_o  (m),
            .act_o   (a)
        );
        assign pend_all[b*BANK_W +: BANK_W] = p;
        assign en_all[b*BANK_W +: BANK_W]   = e;
        assign mask_all[b*BANK_W +: BANK_W] = m;
        assign act_all[b*BANK_W +: BANK_W]  = a;
    end

    intc_prio #(.N(NSRC)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (act_all),
        .found_o (found),
        .idx_o   (win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            ext_q  <= '0;
        end else if (wr_ok) begin
            if (int'(word) == W_PROT) prot_q <= bus_wdata[0];
            if (int'(word) == W_EXT)  ext_q  <= bus_wdata[EXT_W-1:0];
        end
    end

    assign irq_o = found;

    always_comb begin
        bus_rdata = '0;
        if (int'(word) == W_VEC)  bus_rdata = BANK_W'(found ? win : '0) << 2;
        if (int'(word) == W_PROT) bus_rdata = BANK_W'(prot_q);
        if (int'(word) == W_EXT)  bus_rdata = BANK_W'(ext_q);
        for (int b = 0; b < BANKS; b++) begin
            if (int'(word) == W_PEND + b) bus_rdata = pend_all[b*BANK_W +: BANK_W];
            if (int'(word) == W_EN + b)   bus_rdata = en_all[b*BANK_W +: BANK_W];
            if (int'(word) == W_MASK + b) bus_rdata = mask_all[b*BANK_W +: BANK_W];
        end
    end

    // R4 / R5: a raised request points at a pending, enabled, unmasked source
    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_all[win] && en_all[win] && !mask_all[win]));

    // R9: an unprivileged write under protection changes no control state
    a_r9_prot_block: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && prot_q && !bus_priv) |=>
            ($stable(en_all) && $stable(mask_all) && $stable(prot_q) && $stable(ext_q)));
endmodule

// File: tb/sim_intc_vec_top.sv
module sim_intc_vec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic        priv = 1'b1;
    logic [31:0] rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_vec_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_priv(priv), .bus_rdata(rdata), .irq_o(irq)
    );

    // entry: kind[77:76] addr[75:68] data[67:36] exp[35:4] req[3:0]
    // kind 0 write (privileged), 1 read-and-compare, 2 pulse bank addr bits data, 3 check irq
    localparam int NV = 30;
    localparam logic [77:0] TBL [NV] = '{
        {2'd1, 8'h40, 32'h0,        32'h0,        4'd1},  // R1 enable zero
        {2'd2, 8'h01, 32'h00000020, 32'h0,        4'd2},  // source 37
        {2'd1, 8'h14, 32'h0,        32'h00000020, 4'd2},  // R2
        {2'd3, 8'h00, 32'h0,        32'h0,        4'd4},  // R4 not enabled
        {2'd1, 8'h00, 32'h0,        32'h0,        4'd7},  // R7
        {2'd0, 8'h44, 32'h00000020, 32'h0,        4'd4},
        {2'd3, 8'h00, 32'h0,        32'h1,        4'd4},  // R4
        {2'd1, 8'h00, 32'h0,        32'h00000094, 4'd6},  // R6 37*4
        {2'd2, 8'h02, 32'h00000008, 32'h0,        4'd2},  // source 67
        {2'd0, 8'h48, 32'h00000008, 32'h0,        4'd6},
        {2'd1, 8'h00, 32'h0,        32'h00000094, 4'd6},  // R6 lower wins
        {2'd0, 8'h54, 32'h00000020, 32'h0,        4'd5},
        {2'd1, 8'h00, 32'h0,        32'h0000010C, 4'd5},  // R5 67*4
        {2'd0, 8'h14, 32'h00000020, 32'h0,        4'd3},
        {2'd1, 8'h14, 32'h0,        32'h0,        4'd3},  // R3
        {2'd0, 8'h18, 32'h0,        32'h0,        4'd3},
        {2'd1, 8'h18, 32'h0,        32'h00000008, 4'd3},  // R3 zeros keep
        {2'd0, 8'h18, 32'hFFFFFFFF, 32'h0,        4'd3},
        {2'd1, 8'h18, 32'h0,        32'h0,        4'd3},  // R3 all ones
        {2'd3, 8'h00, 32'h0,        32'h0,        4'd7},  // R7
        {2'd1, 8'h00, 32'h0,        32'h0,        4'd7},  // R7
        {2'd0, 8'h0C, 32'h00000003, 32'h0,        4'd10},
        {2'd1, 8'h0C, 32'h0,        32'h00000003, 4'd10}, // R10
        {2'd0, 8'h0C, 32'hFFFFFFFE, 32'h0,        4'd10},
        {2'd1, 8'h0C, 32'h0,        32'h00000002, 4'd10}, // R10 upper bits dropped
        {2'd0, 8'h30, 32'hFFFFFFFF, 32'h0,        4'd11},
        {2'd1, 8'h30, 32'h0,        32'h0,        4'd11}, // R11
        {2'd0, 8'h24, 32'hFFFFFFFF, 32'h0,        4'd11},
        {2'd1, 8'h24, 32'h0,        32'h0,        4'd11}, // R11 fast pending
        {2'd1, 8'h04, 32'h0,        32'h0,        4'd11}  // R11
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input logic p);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1; priv = p;
        @(negedge clk);
        wr = 1'b0; priv = 1'b1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input int req);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, e);
    endtask

    task automatic pulse(input int bank, input logic [31:0] bits);
        @(negedge clk);
        src = src | (96'(bits) << (32 * bank));
        @(negedge clk);
        src = src & ~(96'(bits) << (32 * bank));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h00, 32'h0, 1);
        chk(1, 32'(irq), 32'h0);
        rd_chk(8'h10, 32'h0, 1);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k = TBL[i][77:76];
            logic [7:0] a = TBL[i][75:68];
            logic [31:0] d = TBL[i][67:36];
            logic [31:0] e = TBL[i][35:4];
            int r = int'(TBL[i][3:0]);
            case (k)
                2'd0: wr_reg(a, d, 1'b1);
                2'd1: rd_chk(a, e, r);
                2'd2: pulse(int'(a), d);
                default: begin
                    @(negedge clk); #1;
                    chk(r, 32'(irq), e);
                end
            endcase
        end

        // R9 protection
        wr_reg(8'h08, 32'h1, 1'b1);
        rd_chk(8'h08, 32'h1, 9);
        wr_reg(8'h40, 32'h1, 1'b0);
        rd_chk(8'h40, 32'h0, 9);
        wr_reg(8'h08, 32'h0, 1'b0);
        rd_chk(8'h08, 32'h1, 9);
        wr_reg(8'h40, 32'h4, 1'b1);
        rd_chk(8'h40, 32'h4, 9);
        wr_reg(8'h08, 32'h0, 1'b1);
        wr_reg(8'h40, 32'h0, 1'b0);
        rd_chk(8'h40, 32'h0, 9);

        // R8 set beats simultaneous clear
        pulse(0, 32'h1);
        rd_chk(8'h10, 32'h1, 8);
        @(negedge clk);
        src[0] = 1'b1; addr = 8'h10; wdata = 32'h1; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; src[0] = 1'b0;
        rd_chk(8'h10, 32'h1, 8);
        wr_reg(8'h10, 32'h1, 1'b1);
        rd_chk(8'h10, 32'h0, 8);

        // R12 level source only sets once
        @(negedge clk);
        src[1] = 1'b1;
        rd_chk(8'h10, 32'h2, 12);
        wr_reg(8'h10, 32'h2, 1'b1);
        repeat (3) @(negedge clk);
        rd_chk(8'h10, 32'h0, 12);
        src[1] = 1'b0;

        // R2 / R6 top source 95 and lowest source 0
        wr_reg(8'h48, 32'h80000000, 1'b1);
        pulse(2, 32'h80000000);
        rd_chk(8'h18, 32'h80000000, 2);
        rd_chk(8'h00, 32'h0000017C, 6);
        chk(4, 32'(irq), 32'h1);
        wr_reg(8'h40, 32'h1, 1'b1);
        pulse(0, 32'h1);
        rd_chk(8'h00, 32'h0, 6);
        chk(6, 32'(irq), 32'h1);
        // R3 service loop: clear source 0, vector moves to 95
        wr_reg(8'h10, 32'h1, 1'b1);
        rd_chk(8'h00, 32'h0000017C, 3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule